// File: doc/BRIEF.md
# Burst Address Counter with Load

This block produces the word address that one port of a burst-capable memory uses on each clock. Three active-low controls choose the source of that address: a counter clear that forces zero, a strobe that takes the address bus from outside, and a count enable that steps the address held from the previous cycle. When none of them is asserted, the held address is used again. The priority between the controls is fixed: clear first, then strobe, then count, then hold.

The chosen address reaches the array on the same cycle it is selected. A new external address, a cleared address or a stepped address is therefore used without a dead cycle. The same value is captured on the rising edge and becomes the starting point for the next step or hold. The controls have no link to chip enables, byte enables or the read/write direction. A burst can therefore be set up or stepped while the memory itself is idle.

Top module: `burst_addr_gen`

## Requirements
- R1: While `clr_n` is 0, `acc_addr` is 0, whatever `stb_n`, `cnt_n` and `ext_addr` are.
- R2: While `clr_n` is 1 and `stb_n` is 0, `acc_addr` equals `ext_addr` in the same cycle, whatever `cnt_n` is.
- R3: While `clr_n` and `stb_n` are 1 and `cnt_n` is 0, `acc_addr` equals `held_addr` plus one.
- R4: While `clr_n`, `stb_n` and `cnt_n` are all 1, `acc_addr` equals `held_addr`, and changes on `ext_addr` have no effect.
- R5: Stepping from the all-ones address gives 0.
- R6: After each rising clock edge with `rst_n` at 1, `held_addr` equals the `acc_addr` value that was present just before that edge.
- R7: While `rst_n` is 0, and on the cycle it returns to 1, `held_addr` is 0.
- R8: The width is set by `ADDR_W` (default 14, 16K words). With `ADDR_W` = 13, stepping from 0x1FFF gives 0, whereas the 14-bit version gives 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| ext_addr | input | ADDR_W | External address bus |
| stb_n | input | 1 | Address strobe, active low: take `ext_addr` |
| cnt_n | input | 1 | Count enable, active low: step the held address |
| clr_n | input | 1 | Counter clear, active low: use address 0 |
| acc_addr | output | ADDR_W | Address used for this cycle's access (combinational) |
| held_addr | output | ADDR_W | Registered address that the next step or hold starts from |

## Verification
Directed cases put every control combination against the others. Clear is asserted together with strobe and count, which shows that clear wins. Strobe is asserted with count both on and off, which shows that the external address beats the counter. Hold is tested while `ext_addr` keeps changing, which proves the bus is blocked. A step from all ones is run on a 14-bit and a 13-bit instance side by side, which shows where each width wraps. A long seeded random run then mixes all three controls at skewed rates, so that bursts of steps follow loads and clears. A reset pulse in the middle of the run shows that the held value returns to zero.

// File: rtl/bag_pkg.sv
package bag_pkg;
   // Source selected for the access address, in priority order
   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_BUS  = 2'd1,
      SRC_STEP = 2'd2,
      SRC_KEEP = 2'd3
   } addr_src_e;
endpackage

// File: rtl/bag_select.sv
module bag_select
   import bag_pkg::*;
(
   input  logic      clr_n,
   input  logic      stb_n,
   input  logic      cnt_n,
   output addr_src_e src
);
   always_comb begin
      if (!clr_n)      src = SRC_ZERO;
      else if (!stb_n) src = SRC_BUS;
      else if (!cnt_n) src = SRC_STEP;
      else             src = SRC_KEEP;
   end
endmodule

// File: rtl/bag_incr.sv
module bag_incr #(
   parameter int W = 14
) (
   input  logic [W-1:0] val,
   output logic [W-1:0] val_p1
);
   logic [W:0] carry;
   assign carry[0] = 1'b1;
   // Ripple carry; the carry out of the top bit is dropped, so all ones wraps to zero
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign val_p1[i]  = val[i] ^ carry[i];
      assign carry[i+1] = val[i] & carry[i];
   end
   logic unused_cout;
   assign unused_cout = carry[W];
endmodule

// File: rtl/bag_mux.sv
module bag_mux
   import bag_pkg::*;
#(
   parameter int W = 14
) (
   input  addr_src_e    src,
   input  logic [W-1:0] bus_val,
   input  logic [W-1:0] step_val,
   input  logic [W-1:0] keep_val,
   output logic [W-1:0] out_val
);
   always_comb begin
      unique case (src)
         SRC_ZERO: out_val = '0;
         SRC_BUS:  out_val = bus_val;
         SRC_STEP: out_val = step_val;
         default:  out_val = keep_val;
      endcase
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              stb_n,
   input  logic              cnt_n,
   input  logic              clr_n,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] held_addr
);
   localparam int DEPTH_LOG2 = ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_width
      $error("burst_addr_gen: ADDR_W must be within 1..32");
   end

   addr_src_e         src;
   logic [ADDR_W-1:0] stepped;
   logic [ADDR_W-1:0] held_q;

   bag_select u_sel (
      .clr_n (clr_n),
      .stb_n (stb_n),
      .cnt_n (cnt_n),
      .src   (src)
   );

   bag_incr #(.W(DEPTH_LOG2)) u_inc (
      .val    (held_q),
      .val_p1 (stepped)
   );

   bag_mux #(.W(DEPTH_LOG2)) u_mux (
      .src      (src),
      .bus_val  (ext_addr),
      .step_val (stepped),
      .keep_val (held_q),
      .out_val  (acc_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= '0;
      else        held_q <= acc_addr;
   end

   assign held_addr = held_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              stb_n,
   input logic              cnt_n,
   input logic              clr_n,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [ADDR_W-1:0] held_addr
);
   assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> acc_addr == '0);

   assert_bus_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !stb_n) |-> acc_addr == ext_addr);

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && stb_n && !cnt_n) |-> acc_addr == ADDR_W'(held_addr + 1'b1));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && stb_n && cnt_n) |-> acc_addr == held_addr);

   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && stb_n && !cnt_n && held_addr == '1) |-> acc_addr == '0);

   assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> held_addr == $past(acc_addr));

   assert_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> held_addr == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ext_addr  (ext_addr),
   .stb_n     (stb_n),
   .cnt_n     (cnt_n),
   .clr_n     (clr_n),
   .acc_addr  (acc_addr),
   .held_addr (held_addr)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] ext_addr = '0;
   logic        stb_n = 1'b1, cnt_n = 1'b1, clr_n = 1'b1;
   logic [13:0] acc14, held14;
   logic [12:0] acc13, held13;

   int n_chk = 0;
   int n_bad = 0;
   logic [13:0] m14 = '0;
   logic [12:0] m13 = '0;
   logic [13:0] e14;
   logic [12:0] e13;
   bit finished = 0;

   always #10 clk = ~clk;

   burst_addr_gen #(.ADDR_W(14)) dut_i (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .stb_n(stb_n),
      .cnt_n(cnt_n), .clr_n(clr_n), .acc_addr(acc14), .held_addr(held14));

   burst_addr_gen #(.ADDR_W(13)) dut13_i (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr[12:0]), .stb_n(stb_n),
      .cnt_n(cnt_n), .clr_n(clr_n), .acc_addr(acc13), .held_addr(held13));

   function automatic logic [13:0] pick14(logic [13:0] h, logic [13:0] x,
                                          logic s, logic c, logic r);
      if (!r) return 14'd0;
      if (!s) return x;
      if (!c) return h + 14'd1;
      return h;
   endfunction

   function automatic logic [12:0] pick13(logic [12:0] h, logic [12:0] x,
                                          logic s, logic c, logic r);
      if (!r) return 13'd0;
      if (!s) return x;
      if (!c) return h + 13'd1;
      return h;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive away from the edge, check the same-cycle address, then the captured value
   task automatic step(logic [13:0] x, logic s, logic c, logic r, string req);
      ext_addr = x; stb_n = s; cnt_n = c; clr_n = r;
      #2;
      e14 = pick14(m14, x, s, c, r);
      e13 = pick13(m13, x[12:0], s, c, r);
      check(req, 32'(acc14), 32'(e14));
      check({req, " w13"}, 32'(acc13), 32'(e13));
      @(posedge clk); #2;
      m14 = e14; m13 = e13;
      check("R6", 32'(held14), 32'(m14));
      check("R6 w13", 32'(held13), 32'(m13));
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      @(posedge clk); #2;
      check("R7 reset", 32'(held14), 32'd0);
      check("R7 reset", 32'(acc14), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: strobe loads the bus even with count active
      step(14'h1234, 0, 0, 1, "R2");
      step(14'h0ABC, 0, 1, 1, "R2");
      // R3: stepping
      step(14'h3333, 1, 0, 1, "R3");
      step(14'h2222, 1, 0, 1, "R3");
      // R4: hold while the bus moves
      step(14'h3FF0, 1, 1, 1, "R4");
      step(14'h0001, 1, 1, 1, "R4");
      check("R4 held", 32'(held14), 32'h0ABE);
      // R1: clear beats strobe and count
      step(14'h1555, 0, 0, 0, "R1");
      step(14'h2AAA, 1, 0, 0, "R1");
      // R5: wrap of the 14-bit instance
      step(14'h3FFF, 0, 1, 1, "R5");
      step(14'h0000, 1, 0, 1, "R5");
      check("R5 wrap", 32'(held14), 32'h0000);
      // R8: 13-bit wraps at 0x1FFF, 14-bit does not
      step(14'h1FFF, 0, 1, 1, "R8");
      step(14'h0000, 1, 0, 1, "R8");
      check("R8 w14", 32'(held14), 32'h2000);
      check("R8 w13", 32'(held13), 32'h0000);
      // Random mix
      for (int i = 0; i < 600; i++) begin
         logic [13:0] x;
         logic s, c, r;
         x = 14'($urandom);
         if (($urandom % 8) == 0) x = 14'h3FFF - 14'($urandom % 3);
         s = ($urandom % 5) != 0;
         c = ($urandom % 3) == 0;
         r = ($urandom % 12) != 0;
         step(x, s, c, r, "R1-4 rand");
         if (i == 300) begin
            rst_n = 1'b0; #2;
            check("R7 mid", 32'(held14), 32'd0);
            check("R7 mid", 32'(held13), 32'd0);
            m14 = '0; m13 = '0;
            @(posedge clk); #2;
            rst_n = 1'b1;
            check("R7 after", 32'(held14), 32'd0);
         end
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule